// File: doc/BRIEF.md
# Byte-Paired FIFO Access Bridge

The bridge links an 8-bit host bus to a device whose per-socket transmit and receive data FIFOs are 16 bits wide. The host reaches everything indirectly. It writes a target code into an address register, then moves bytes through a low data port and a high data port. A bridge-local control port gives error clearing and a receive-done command. Targets other than the two FIFOs are ordinary byte registers, modelled as a small scratch register file.

FIFO traffic is always carried as whole 16-bit words. A transmit low byte is staged, and the word is pushed only when the matching high byte arrives. A receive word is popped on the low-byte read, and its upper half is held for the high-byte read that follows. Once a FIFO low byte has been touched, only the matching high byte may come next. The bridge also refuses a receive FIFO access that directly follows transmit FIFO traffic, until an unrelated register access sits in between. A rule-breaking access has no FIFO side effect and sets a sticky error flag.

Top module: `fifo_pair_bridge`

## Requirements
- R1: After reset these outputs are low: `err_o`, `rdata_o`, `tx_valid_o` and `rx_done_o`. `rx_ready_o` is high.
- R2: `port_i` codes are 0 address register, 1 low data port, 2 high data port, 3 control. A target code that is neither FIFO and is below the register count selects one scratch byte register, reached through either data port. Other codes read 0 and drop writes. A read on the address port returns the target code. Read data appears on `rdata_o` one clock after the access.
- R3: With target 0x20 (transmit FIFO), a low-port write stages a byte. The high-port write then pushes the word {high,low}, so an odd packet length is padded by writing a dummy high byte.
- R4: With target 0x22 (receive FIFO), a low-port read pops one word and returns bits 7:0. The following high-port read returns bits 15:8 of that same word.
- R5: While a FIFO low byte is pending, any data-side access other than the matching high byte is flagged and ignored. This includes address-register writes and reads, and a violating read returns 0. The pending word stays open.
- R6: A high-port access to a FIFO target with no pending low byte is flagged and pushes or pops nothing.
- R7: A receive FIFO low read that follows an accepted transmit low write is flagged and pops nothing, unless a scratch register access or a receive-done command came in between.
- R8: `err_o` is sticky. Writing the control port with bit 0 set clears it and abandons any pending low byte. Control port reads return the flag in bit 0.
- R9: Writing the control port with bit 1 set raises `rx_done_o` for exactly one clock and clears the transmit-to-receive turnaround condition.
- R10: The following are flagged and ignored: a transmit low write while the transmit FIFO is full, a receive low read while the receive FIFO is empty (which returns 0), a read of the transmit FIFO, and a write of the receive FIFO.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` stays stable. Words leave in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | 1 write, 0 read |
| port_i | input | 2 | Host port select |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte, registered |
| err_o | output | 1 | Sticky rule-violation flag |
| tx_data_o | output | 16 | Transmit word to device |
| tx_valid_o | output | 1 | Transmit word available |
| tx_ready_i | input | 1 | Device takes transmit word |
| rx_data_i | input | 16 | Receive word from device |
| rx_valid_i | input | 1 | Receive word offered |
| rx_ready_o | output | 1 | Receive FIFO has room |
| rx_done_o | output | 1 | One-cycle receive-done pulse |

## Verification
A stuck lock shows up on the very next access. A legal address write is then flagged, and `err_o` rises one clock later. A lost or doubled pop skews the receive byte stream, and the next high-port read returns the wrong half. A staged byte that is wrongly dropped or kept appears as a bad word on `tx_data_o` when the device drains it. A turnaround flag that is not cleared turns a legal receive read into a zero byte and a raised error in the following cycle.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_DLO  = 2'd1,
    PORT_DHI  = 2'd2,
    PORT_CTRL = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_TX   = 2'd1,
    LK_RX   = 2'd2
  } lock_e;

  localparam logic [7:0] TGT_TXF = 8'h20;
  localparam logic [7:0] TGT_RXF = 8'h22;
  localparam int CTL_CLR  = 0;
  localparam int CTL_DONE = 1;
endpackage

// File: rtl/fpb_word_fifo.sv
module fpb_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fpb_guard.sv
module fpb_guard
  import fpb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       we_i,
  input  port_e      port_i,
  input  logic [7:0] tgt_i,
  input  logic       tx_full_i,
  input  logic       rx_empty_i,
  input  logic       ctl_clr_i,
  input  logic       ctl_done_i,
  output logic       addr_acc_o,
  output logic       reg_acc_o,
  output logic       tx_lo_o,
  output logic       tx_push_o,
  output logic       rx_pop_o,
  output logic       rx_hi_o,
  output logic       viol_o,
  output logic       err_o,
  output lock_e      lock_o
);
  lock_e lock_q;
  logic  tx_recent_q, err_q;
  logic  is_tx, is_rx;

  assign is_tx  = (tgt_i == TGT_TXF);
  assign is_rx  = (tgt_i == TGT_RXF);
  assign lock_o = lock_q;
  assign err_o  = err_q;

  always_comb begin
    addr_acc_o = 1'b0;
    reg_acc_o  = 1'b0;
    tx_lo_o    = 1'b0;
    tx_push_o  = 1'b0;
    rx_pop_o   = 1'b0;
    rx_hi_o    = 1'b0;
    viol_o     = 1'b0;
    if (acc_i && port_i != PORT_CTRL) begin
      if (lock_q != LK_NONE) begin
        // only the matching high byte may follow a FIFO low byte
        if (port_i == PORT_DHI && lock_q == LK_TX && we_i)       tx_push_o = 1'b1;
        else if (port_i == PORT_DHI && lock_q == LK_RX && !we_i) rx_hi_o   = 1'b1;
        else                                                     viol_o    = 1'b1;
      end else if (port_i == PORT_ADDR) begin
        addr_acc_o = 1'b1;
      end else if (!is_tx && !is_rx) begin
        reg_acc_o = 1'b1;
      end else if (port_i == PORT_DHI) begin
        viol_o = 1'b1;
      end else if (is_tx) begin
        if (we_i && !tx_full_i) tx_lo_o = 1'b1;
        else                    viol_o  = 1'b1;
      end else begin
        if (!we_i && !rx_empty_i && !tx_recent_q) rx_pop_o = 1'b1;
        else                                      viol_o   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= LK_NONE;
      tx_recent_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (ctl_clr_i)                  lock_q <= LK_NONE;
      else if (tx_lo_o)               lock_q <= LK_TX;
      else if (rx_pop_o)              lock_q <= LK_RX;
      else if (tx_push_o || rx_hi_o)  lock_q <= LK_NONE;

      if (tx_lo_o)                       tx_recent_q <= 1'b1;
      else if (reg_acc_o || ctl_done_i)  tx_recent_q <= 1'b0;

      if (ctl_clr_i)   err_q <= 1'b0;
      else if (viol_o) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_pair_bridge.sv
module fifo_pair_bridge
  import fpb_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic        we_i,
  input  logic [1:0]  port_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        err_o,
  output logic [15:0] tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [15:0] rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic        rx_done_o
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  port_e       port_w;
  lock_e       lock_w;
  logic [7:0]  tgt_q, stage_q, hold_q, rdata_q;
  logic [7:0]  regs_q [NREG];
  logic        done_q;
  logic        is_ctrl, ctl_clr, ctl_done;
  logic        addr_acc_w, reg_acc_w, tx_lo_w, tx_push_w, rx_pop_w, rx_hi_w, viol_w;
  logic        tx_full_w, tx_empty_w, rx_full_w, rx_empty_w;
  logic [15:0] rx_word_w;
  logic        reg_hit;
  logic [IDX_W-1:0] reg_idx;

  assign port_w   = port_e'(port_i);
  assign is_ctrl  = acc_i && port_w == PORT_CTRL;
  assign ctl_clr  = is_ctrl && we_i && wdata_i[CTL_CLR];
  assign ctl_done = is_ctrl && we_i && wdata_i[CTL_DONE];
  assign reg_hit  = (tgt_q < 8'(NREG));
  assign reg_idx  = tgt_q[IDX_W-1:0];

  fpb_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc_i),
    .we_i       (we_i),
    .port_i     (port_w),
    .tgt_i      (tgt_q),
    .tx_full_i  (tx_full_w),
    .rx_empty_i (rx_empty_w),
    .ctl_clr_i  (ctl_clr),
    .ctl_done_i (ctl_done),
    .addr_acc_o (addr_acc_w),
    .reg_acc_o  (reg_acc_w),
    .tx_lo_o    (tx_lo_w),
    .tx_push_o  (tx_push_w),
    .rx_pop_o   (rx_pop_w),
    .rx_hi_o    (rx_hi_w),
    .viol_o     (viol_w),
    .err_o      (err_o),
    .lock_o     (lock_w)
  );

  fpb_word_fifo #(.W(16), .DEPTH(TX_DEPTH)) u_txf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push_w),
    .din_i   ({wdata_i, stage_q}),
    .pop_i   (tx_ready_i),
    .dout_o  (tx_data_o),
    .empty_o (tx_empty_w),
    .full_o  (tx_full_w)
  );

  fpb_word_fifo #(.W(16), .DEPTH(RX_DEPTH)) u_rxf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .din_i   (rx_data_i),
    .pop_i   (rx_pop_w),
    .dout_o  (rx_word_w),
    .empty_o (rx_empty_w),
    .full_o  (rx_full_w)
  );

  assign tx_valid_o = !tx_empty_w;
  assign rx_ready_o = !rx_full_w;
  assign rdata_o    = rdata_q;
  assign rx_done_o  = done_q;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                                   regs_q[g] <= '0;
        else if (reg_acc_w && we_i && reg_hit && reg_idx == IDX_W'(g)) regs_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= '0;
      stage_q <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= ctl_done;
      if (addr_acc_w && we_i) tgt_q   <= wdata_i;
      if (tx_lo_w)            stage_q <= wdata_i;
      if (rx_pop_w)           hold_q  <= rx_word_w[15:8];
      if (acc_i && !we_i) begin
        if (is_ctrl)        rdata_q <= {7'b0, err_o};
        else if (addr_acc_w) rdata_q <= tgt_q;
        else if (reg_acc_w)  rdata_q <= reg_hit ? regs_q[reg_idx] : 8'h00;
        else if (rx_pop_w)   rdata_q <= rx_word_w[7:0];
        else if (rx_hi_w)    rdata_q <= hold_q;
        else                 rdata_q <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_i,
  input logic        we_i,
  input logic [1:0]  port_i,
  input logic        err_o,
  input logic        rx_done_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [15:0] tx_data_o,
  input logic        viol_i,
  input logic        tx_push_i,
  input logic        rx_pop_i,
  input logic [1:0]  lock_i
);
  // R8: a violation leaves the flag raised
  p_viol_sets_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> err_o);

  // R9: pulse only after a control write
  p_done_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(acc_i && we_i && port_i == 2'd3));

  // R5: while locked, anything but the high byte or control is refused
  p_lock_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i != 2'd0 && acc_i && port_i != 2'd2 && port_i != 2'd3) |-> viol_i);

  // R5: a refused access has no FIFO effect
  p_one_effect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_push_i, rx_pop_i, viol_i}));

  // R11: held word stays put
  p_tx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind fifo_pair_bridge fpb_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_i      (acc_i),
  .we_i       (we_i),
  .port_i     (port_i),
  .err_o      (err_o),
  .rx_done_o  (rx_done_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .viol_i     (viol_w),
  .tx_push_i  (tx_push_w),
  .rx_pop_i   (rx_pop_w),
  .lock_i     (lock_w)
);

// File: tb/fifo_pair_bridge_test.sv
module fifo_pair_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {we, port[1:0], wdata[7:0], chk, exp_rd[7:0], exp_err}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h01, 1'b0, 8'h00, 1'b0},
    {1'b1, 2'd1, 8'hA5, 1'b0, 8'h00, 1'b0},
    {1'b0, 2'd2, 8'h00, 1'b1, 8'hA5, 1'b0},
    {1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 1'b0},
    {1'b1, 2'd0, 8'h03, 1'b0, 8'h00, 1'b0},
    {1'b1, 2'd2, 8'h5C, 1'b0, 8'h00, 1'b0},
    {1'b0, 2'd1, 8'h00, 1'b1, 8'h5C, 1'b0},
    {1'b1, 2'd0, 8'h07, 1'b0, 8'h00, 1'b0},
    {1'b1, 2'd1, 8'h11, 1'b0, 8'h00, 1'b0},
    {1'b0, 2'd1, 8'h00, 1'b1, 8'h00, 1'b0},
    {1'b0, 2'd3, 8'h00, 1'b1, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 1'b0, we = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [1:0] port = '0;
  logic [7:0] wdata = '0, rdata;
  logic [15:0] tx_data, rx_data = '0;
  logic err, tx_valid, rx_ready, rx_done;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_pair_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .we_i(we), .port_i(port),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_done_o(rx_done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    acc = 1'b1; we = w; port = p; wdata = d;
    @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic feed(input logic [15:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain(input logic [15:0] exp);
    chk("R11 drain valid", 16'(tx_valid), 16'h1);
    chk("R11 drain order", tx_data, exp);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 err", 16'(err), 16'h0);
    chk("R1 rdata", 16'(rdata), 16'h0);
    chk("R1 tx_valid", 16'(tx_valid), 16'h0);
    chk("R1 rx_done", 16'(rx_done), 16'h0);
    chk("R1 rx_ready", 16'(rx_ready), 16'h1);
    rst_n = 1'b1;

    // R2 table
    for (int i = 0; i < NVEC; i++) begin
      bus(VEC[i][20], VEC[i][19:18], VEC[i][17:10]);
      if (VEC[i][9]) chk("R2 rdata", 16'(rdata), 16'(VEC[i][8:1]));
      chk("R2 err", 16'(err), 16'(VEC[i][0]));
    end

    // R3 word push and odd padding
    bus(1, 0, 8'h20);
    bus(1, 1, 8'h34);
    chk("R3 no push on low", 16'(tx_valid), 16'h0);
    bus(1, 2, 8'h12);
    chk("R3 word", tx_data, 16'h1234);
    bus(1, 1, 8'h77);
    bus(1, 2, 8'h00);
    chk("R11 held", tx_data, 16'h1234);
    chk("R3 err", 16'(err), 16'h0);

    // R7 turnaround
    bus(1, 0, 8'h22);
    feed(16'hBEEF);
    bus(0, 1, 8'h00);
    chk("R7 flagged", 16'(err), 16'h1);
    chk("R7 rdata", 16'(rdata), 16'h0);
    bus(1, 3, 8'h01);
    chk("R8 cleared", 16'(err), 16'h0);
    bus(1, 0, 8'h00);
    bus(0, 1, 8'h00);
    bus(1, 0, 8'h22);
    bus(0, 1, 8'h00);
    chk("R4 low byte", 16'(rdata), 16'h00EF);
    bus(0, 2, 8'h00);
    chk("R4 high byte", 16'(rdata), 16'h00BE);
    chk("R4 err", 16'(err), 16'h0);

    // R5 lock
    bus(1, 0, 8'h20);
    bus(1, 1, 8'h99);
    bus(1, 0, 8'h22);
    chk("R5 addr write flagged", 16'(err), 16'h1);
    bus(0, 0, 8'h00);
    chk("R5 locked read zero", 16'(rdata), 16'h0);
    bus(0, 3, 8'h00);
    chk("R8 ctrl read flag", 16'(rdata), 16'h1);
    bus(1, 2, 8'h88);
    bus(1, 3, 8'h01);

    // R6 high without low
    bus(1, 2, 8'h55);
    chk("R6 flagged", 16'(err), 16'h1);
    bus(1, 3, 8'h01);

    // R8 clear abandons lock
    bus(1, 1, 8'h66);
    bus(1, 3, 8'h01);
    bus(1, 0, 8'h01);
    chk("R8 lock dropped", 16'(err), 16'h0);
    bus(0, 1, 8'h00);
    chk("R8 reg read", 16'(rdata), 16'h00A5);

    // R10 full
    bus(1, 0, 8'h20);
    bus(1, 1, 8'h01);
    bus(1, 2, 8'h02);
    chk("R10 not flagged", 16'(err), 16'h0);
    bus(1, 1, 8'h03);
    chk("R10 full flagged", 16'(err), 16'h1);
    bus(1, 3, 8'h01);
    drain(16'h1234);
    drain(16'h0077);
    drain(16'h8899);
    drain(16'h0201);
    chk("R11 empty", 16'(tx_valid), 16'h0);

    // R9 done clears turnaround
    bus(1, 0, 8'h22);
    feed(16'hC0DE);
    bus(1, 3, 8'h02);
    chk("R9 pulse high", 16'(rx_done), 16'h1);
    @(negedge clk);
    chk("R9 pulse low", 16'(rx_done), 16'h0);
    bus(0, 1, 8'h00);
    chk("R9 read allowed", 16'(rdata), 16'h00DE);
    chk("R9 err", 16'(err), 16'h0);
    bus(0, 2, 8'h00);
    chk("R4 high second", 16'(rdata), 16'h00C0);

    // R10 empty and direction
    bus(0, 1, 8'h00);
    chk("R10 empty flagged", 16'(err), 16'h1);
    chk("R10 empty rdata", 16'(rdata), 16'h0);
    bus(1, 3, 8'h01);
    bus(1, 1, 8'h44);
    chk("R10 rx write flagged", 16'(err), 16'h1);
    bus(1, 3, 8'h01);
    bus(1, 0, 8'h20);
    bus(0, 1, 8'h00);
    chk("R10 tx read flagged", 16'(err), 16'h1);
    chk("R10 tx no push", 16'(tx_valid), 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule